// File: doc/BRIEF.md
# Monochrome Character Display Generator

This block turns a 40-column by 25-row character screen held in video RAM into a 320 by 200 serial monochrome pixel stream. Each character cell is 8 pixels wide and 8 lines tall. For each cell the block reads a character code from video RAM. That code, together with the line inside the cell, addresses one byte of an 8x8 pattern memory. The block then shifts the byte out most significant bit first. Both memories sit outside the block, and each returns its data one clock after the address.

A processor controls three display features by reading from fixed addresses:
- **Vertical scroll:** shifts the video RAM pointer by eight cells per step, wrapping within 2 KB.
- **Whole-screen inversion:** inverts every pattern byte.
- **Blanking gate:** a separate input that blanks the picture.

The block also drives two status flags for the processor. One is high on the visible lines of the frame. The other is high during the first part of every line. One clock is one pixel. The raster runs through a configurable number of clocks per line and lines per frame. Lines below the visible area carry only dark pixels.

Top module: `txt_video_gen`

## Requirements
- R1: A line lasts H_TOTAL clocks and a frame lasts V_TOTAL lines. The raster starts at position 0 of line 0 when reset is released. `line_start` is high exactly at clock 0 of each line. `frame_start` is high exactly at clock 0 of line 0.
- R2: On a visible line v, at clock 8c of the line (column c < COLS), `vram_addr` equals ((v/8)*COLS + scroll*8 + c) modulo 2048. `vram_data` is expected on the next clock.
- R3: One clock after the video RAM address, `pat_addr` equals code*8 + (v mod 8), where code is the byte returned on `vram_data`.
- R4: Pixel x (0..COLS*8-1) of visible line v is output on `pix` at clock x+3 of the line, with pattern bit 7 leftmost. Every other clock of every line is 0, and this includes all lines at or beyond ROWS*8.
- R5: While `gate` is low, the pattern byte is forced to zero. This happens before inversion, so with inversion set the visible pixels are all 1.
- R6: While the reverse flag is set, each visible pattern byte is inverted before it is shifted out.
- R7: A read (`cpu_rd` high) of address 16'hE014 clears the reverse flag, and a read of 16'hE015 sets it. The change takes effect from the next clock. Reset clears the flag.
- R8: A read of any address whose upper byte is 8'hE2 loads the scroll value with the low address byte. Reset sets scroll to 0.
- R9: Reads of any other address, and any address presented while `cpu_rd` is low, leave scroll and the reverse flag unchanged.
- R10: `vdisp` goes high at the start of line 0. It goes low at the start of line ROWS*8 and stays low for the rest of the frame.
- R11: `hblank` is high for the first HB_CLKS clocks of every line and low for the rest of the line.
- R12: During reset and right after it, the outputs show raster position 0 of line 0: `line_start`, `frame_start`, `vdisp` and `hblank` are 1 and `pix` is 0. Scroll is 0 and reverse is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Processor read strobe, one pulse per clock |
| cpu_addr | input | 16 | Processor address decoded on reads |
| gate | input | 1 | Picture enable; low blanks the pattern |
| vram_addr | output | 11 | Video RAM read address |
| vram_data | input | 8 | Character code, valid one clock after the address |
| pat_addr | output | 11 | Pattern memory read address |
| pat_data | input | 8 | Pattern byte, valid one clock after the address |
| pix | output | 1 | Serial pixel |
| line_start | output | 1 | First clock of each line |
| frame_start | output | 1 | First clock of each frame |
| vdisp | output | 1 | High while the raster is on visible lines |
| hblank | output | 1 | High for the first HB_CLKS clocks of each line |

## Verification
Gating and inversion both act on the same pattern byte in the same load cycle, so their order is observable. The bench lowers `gate` and sets reverse during a vertical blank. It then expects every visible pixel of the next frame to read 1, which is the result of zeroing first and inverting second. It also expects every pixel outside the visible window to stay 0. In a separate frame, scroll is set to 8'hFF, which forces the video RAM address past 2047 within row 0. Every fetch address is then compared against a modulo-2048 model, and randomly seeded memory contents are traced through to the pixels.

// File: rtl/txt_video_pkg.sv
package txt_video_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_REV_CLR = 2'd1,
        CMD_REV_SET = 2'd2,
        CMD_SCROLL  = 2'd3
    } reg_cmd_e;

    localparam int unsigned PIX_PER_CELL = 8;
    localparam int unsigned PIPE_LAT     = 3;

endpackage

// File: rtl/txt_raster.sv
module txt_raster #(
    parameter int unsigned H_TOTAL   = 400,
    parameter int unsigned V_TOTAL   = 262,
    parameter int unsigned VIS_LINES = 200,
    parameter int unsigned HB_CLKS   = 92,
    parameter int unsigned HW        = $clog2(H_TOTAL),
    parameter int unsigned VW        = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt_o,
    output logic [VW-1:0] vcnt_o,
    output logic          line_start_o,
    output logic          frame_start_o,
    output logic          vdisp_o,
    output logic          hblank_o
);
    localparam int unsigned HBW = $clog2(HB_CLKS + 1);
    localparam logic [HW-1:0]  H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0]  V_LAST = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0]  V_VIS  = VW'(VIS_LINES);
    localparam logic [HBW-1:0] HB_LD  = HBW'(HB_CLKS);

    typedef struct packed {
        logic [HW-1:0]  hcnt;
        logic [VW-1:0]  vcnt;
        logic           vdisp;
        logic [HBW-1:0] hbc;
    } raster_t;

    raster_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.hcnt == H_LAST) begin
            st_d.hcnt = '0;
            st_d.vcnt = (st_q.vcnt == V_LAST) ? '0 : st_q.vcnt + 1'b1;
            st_d.hbc  = HB_LD;
            if (st_d.vcnt == '0) begin
                st_d.vdisp = 1'b1;
            end else if (st_d.vcnt == V_VIS) begin
                st_d.vdisp = 1'b0;
            end
        end else begin
            st_d.hcnt = st_q.hcnt + 1'b1;
            if (st_q.hbc != '0) begin
                st_d.hbc = st_q.hbc - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hcnt: '0, vcnt: '0, vdisp: 1'b1, hbc: HB_LD};
        end else begin
            st_q <= st_d;
        end
    end

    assign hcnt_o        = st_q.hcnt;
    assign vcnt_o        = st_q.vcnt;
    assign line_start_o  = (st_q.hcnt == '0);
    assign frame_start_o = (st_q.hcnt == '0) && (st_q.vcnt == '0);
    assign vdisp_o       = st_q.vdisp;
    assign hblank_o      = (st_q.hbc != '0);

    // R11: the flag is raised at every line start
    assert_hblank_at_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |-> hblank_o);

    // R11: the flag drops exactly HB_CLKS clocks into the line
    assert_hblank_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hblank_o) |-> (hcnt_o == HW'(HB_CLKS)));

    // R10: the visible flag only rises at the frame start
    assert_vdisp_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vdisp_o) |-> frame_start_o);

    // R1: a line start is followed by a non-start clock
    assert_line_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |=> !line_start_o);

endmodule

// File: rtl/txt_cpu_regs.sv
module txt_cpu_regs
    import txt_video_pkg::*;
#(
    parameter logic [15:0] REV_CLR_ADDR = 16'hE014,
    parameter logic [15:0] REV_SET_ADDR = 16'hE015,
    parameter logic [7:0]  SCROLL_PAGE  = 8'hE2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_rd_i,
    input  logic [15:0] cpu_addr_i,
    output logic        rev_o,
    output logic [7:0]  scroll_o
);
    typedef struct packed {
        logic       rev;
        logic [7:0] scroll;
    } ctl_t;

    ctl_t     st_d, st_q;
    reg_cmd_e cmd;

    always_comb begin
        cmd = CMD_NONE;
        if (cpu_rd_i) begin
            if (cpu_addr_i == REV_CLR_ADDR) begin
                cmd = CMD_REV_CLR;
            end else if (cpu_addr_i == REV_SET_ADDR) begin
                cmd = CMD_REV_SET;
            end else if (cpu_addr_i[15:8] == SCROLL_PAGE) begin
                cmd = CMD_SCROLL;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_REV_CLR: st_d.rev    = 1'b0;
            CMD_REV_SET: st_d.rev    = 1'b1;
            CMD_SCROLL:  st_d.scroll = cpu_addr_i[7:0];
            default:     st_d        = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rev_o    = st_q.rev;
    assign scroll_o = st_q.scroll;

    // R7: a set read turns inversion on from the next clock
    assert_rev_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && cpu_addr_i == REV_SET_ADDR) |=> rev_o);

    // R8: a read in the scroll page latches the low address byte
    assert_scroll_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && cpu_addr_i[15:8] == SCROLL_PAGE) |=> (scroll_o == $past(cpu_addr_i[7:0])));

    // R9: no strobe, no change
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd_i |=> ($stable(rev_o) && $stable(scroll_o)));

endmodule

// File: rtl/txt_fetch.sv
module txt_fetch
    import txt_video_pkg::*;
#(
    parameter int unsigned COLS       = 40,
    parameter int unsigned CELL_H     = 8,
    parameter int unsigned VIS_LINES  = 200,
    parameter int unsigned SCROLL_MUL = 8,
    parameter int unsigned VRAM_AW    = 11,
    parameter int unsigned HW         = 9,
    parameter int unsigned VW         = 9,
    parameter int unsigned CELL_BITS  = $clog2(CELL_H),
    parameter int unsigned PAT_AW     = 8 + CELL_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HW-1:0]      hcnt_i,
    input  logic [VW-1:0]      vcnt_i,
    input  logic [7:0]         scroll_i,
    input  logic               rev_i,
    input  logic               gate_i,
    output logic [VRAM_AW-1:0] vram_addr_o,
    input  logic [7:0]         vram_data_i,
    output logic [PAT_AW-1:0]  pat_addr_o,
    input  logic [7:0]         pat_data_i,
    output logic               pix_o
);
    localparam int unsigned PH_BITS = $clog2(PIX_PER_CELL);
    localparam logic [VW-1:0] V_VIS = VW'(VIS_LINES);

    typedef struct packed {
        logic       v1;
        logic       v2;
        logic [7:0] sh;
    } fetch_t;

    fetch_t      st_d, st_q;
    logic        fetch_a;
    logic [31:0] row32, col32, sum32;
    logic [7:0]  pat_g;

    always_comb begin
        row32   = 32'(vcnt_i >> CELL_BITS);
        col32   = 32'(hcnt_i >> PH_BITS);
        sum32   = row32 * COLS + 32'(scroll_i) * SCROLL_MUL + col32;
        fetch_a = (vcnt_i < V_VIS) && (hcnt_i[PH_BITS-1:0] == '0) && (col32 < COLS);
    end

    assign vram_addr_o = sum32[VRAM_AW-1:0];
    assign pat_addr_o  = {vram_data_i, vcnt_i[CELL_BITS-1:0]};

    always_comb begin
        pat_g = gate_i ? pat_data_i : 8'h00;
        if (rev_i) begin
            pat_g = ~pat_g;
        end
        st_d    = st_q;
        st_d.v1 = fetch_a;
        st_d.v2 = st_q.v1;
        st_d.sh = st_q.v2 ? pat_g : {st_q.sh[6:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o = st_q.sh[7];

    // R4: lines below the visible window stay dark
    assert_blank_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vcnt_i >= V_VIS) |-> !pix_o);

endmodule

// File: rtl/txt_video_gen.sv
module txt_video_gen
    import txt_video_pkg::*;
#(
    parameter int unsigned COLS         = 40,
    parameter int unsigned ROWS         = 25,
    parameter int unsigned CELL_H       = 8,
    parameter int unsigned H_TOTAL      = 400,
    parameter int unsigned V_TOTAL      = 262,
    parameter int unsigned HB_CLKS      = 92,
    parameter int unsigned SCROLL_MUL   = 8,
    parameter int unsigned VRAM_AW      = 11,
    parameter logic [15:0] REV_CLR_ADDR = 16'hE014,
    parameter logic [15:0] REV_SET_ADDR = 16'hE015,
    parameter logic [7:0]  SCROLL_PAGE  = 8'hE2,
    localparam int unsigned PAT_AW      = 8 + $clog2(CELL_H)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_rd,
    input  logic [15:0]        cpu_addr,
    input  logic               gate,
    output logic [VRAM_AW-1:0] vram_addr,
    input  logic [7:0]         vram_data,
    output logic [PAT_AW-1:0]  pat_addr,
    input  logic [7:0]         pat_data,
    output logic               pix,
    output logic               line_start,
    output logic               frame_start,
    output logic               vdisp,
    output logic               hblank
);
    localparam int unsigned VIS_LINES = ROWS * CELL_H;
    localparam int unsigned HW        = $clog2(H_TOTAL);
    localparam int unsigned VW        = $clog2(V_TOTAL);

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          rev;
    logic [7:0]    scroll;

    txt_raster #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .VIS_LINES(VIS_LINES),
        .HB_CLKS(HB_CLKS), .HW(HW), .VW(VW)
    ) i_raster (
        .clk(clk), .rst_n(rst_n), .hcnt_o(hcnt), .vcnt_o(vcnt),
        .line_start_o(line_start), .frame_start_o(frame_start),
        .vdisp_o(vdisp), .hblank_o(hblank)
    );

    txt_cpu_regs #(
        .REV_CLR_ADDR(REV_CLR_ADDR), .REV_SET_ADDR(REV_SET_ADDR),
        .SCROLL_PAGE(SCROLL_PAGE)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .cpu_rd_i(cpu_rd), .cpu_addr_i(cpu_addr),
        .rev_o(rev), .scroll_o(scroll)
    );

    txt_fetch #(
        .COLS(COLS), .CELL_H(CELL_H), .VIS_LINES(VIS_LINES),
        .SCROLL_MUL(SCROLL_MUL), .VRAM_AW(VRAM_AW), .HW(HW), .VW(VW),
        .PAT_AW(PAT_AW)
    ) i_fetch (
        .clk(clk), .rst_n(rst_n), .hcnt_i(hcnt), .vcnt_i(vcnt),
        .scroll_i(scroll), .rev_i(rev), .gate_i(gate),
        .vram_addr_o(vram_addr), .vram_data_i(vram_data),
        .pat_addr_o(pat_addr), .pat_data_i(pat_data), .pix_o(pix)
    );

endmodule

// File: tb/test_txt_video_gen.sv
module test_txt_video_gen;
    localparam int COLS = 40, ROWS = 13, CELL_H = 8;
    localparam int H_TOTAL = 330, V_TOTAL = 108, HB_CLKS = 92;
    localparam int VIS = ROWS * CELL_H;

    logic        clk = 1'b0, rst_n = 1'b0, cpu_rd = 1'b0, gate = 1'b1;
    logic [15:0] cpu_addr = 16'h0;
    logic [10:0] vram_addr, pat_addr;
    logic [7:0]  vram_q, pat_q;
    logic        pix, line_start, frame_start, vdisp, hblank;
    logic [7:0]  vram_mem [0:2047];
    logic [7:0]  pat_mem  [0:2047];

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    int    m_scroll = 0;
    bit    m_rev = 1'b0, m_gate = 1'b1;
    int    rnd_scroll;
    string tag = "R4";

    always #4 clk = ~clk;

    txt_video_gen #(
        .COLS(COLS), .ROWS(ROWS), .CELL_H(CELL_H), .H_TOTAL(H_TOTAL),
        .V_TOTAL(V_TOTAL), .HB_CLKS(HB_CLKS)
    ) i_txt_video_gen (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .gate(gate), .vram_addr(vram_addr), .vram_data(vram_q),
        .pat_addr(pat_addr), .pat_data(pat_q), .pix(pix),
        .line_start(line_start), .frame_start(frame_start),
        .vdisp(vdisp), .hblank(hblank)
    );

    always_ff @(posedge clk) begin
        vram_q <= vram_mem[vram_addr];
        pat_q  <= pat_mem[pat_addr];
    end

    task automatic chk(input bit ok, input string t, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", t, act, exp);
        end
    endtask

    // model of the register decode, written from R7, R8 and R9
    task automatic do_read(input bit rd, input logic [15:0] a);
        cpu_rd   = rd;
        cpu_addr = a;
        if (rd) begin
            if (a == 16'hE014)           m_rev = 1'b0;
            else if (a == 16'hE015)      m_rev = 1'b1;
            else if (a[15:8] == 8'hE2)   m_scroll = int'(a[7:0]);
        end
    endtask

    function automatic int exp_idx(input int v, input int col);
        return ((v / 8) * COLS + m_scroll * 8 + col) % 2048;
    endfunction

    function automatic bit exp_pix(input int h, input int v);
        int x;
        logic [7:0] p;
        x = h - 3;
        if (v >= VIS || x < 0 || x >= COLS * 8) return 1'b0;
        p = pat_mem[int'(vram_mem[exp_idx(v, x / 8)]) * 8 + v % 8];
        if (!m_gate) p = 8'h00;
        if (m_rev)   p = ~p;
        return p[7 - x % 8];
    endfunction

    task automatic check_cycle(input int h, input int v);
        int col;
        int ea;
        bit ep;
        chk(line_start == (h == 0), "R1 line_start", line_start, h == 0);
        chk(frame_start == (h == 0 && v == 0), "R1 frame_start", frame_start, h == 0 && v == 0);
        chk(vdisp == (v < VIS), "R10 vdisp", vdisp, v < VIS);
        chk(hblank == (h < HB_CLKS), "R11 hblank", hblank, h < HB_CLKS);
        ep = exp_pix(h, v);
        chk(pix == ep, {"R4 pixel ", tag}, pix, ep);
        if (v < VIS && h % 8 == 0 && h / 8 < COLS) begin
            ea = exp_idx(v, h / 8);
            chk(int'(vram_addr) == ea, "R2 vram_addr", vram_addr, ea);
        end
        if (v < VIS && h % 8 == 1 && (h - 1) / 8 < COLS) begin
            col = (h - 1) / 8;
            ea  = int'(vram_mem[exp_idx(v, col)]) * 8 + v % 8;
            chk(int'(pat_addr) == ea, "R3 pat_addr", pat_addr, ea);
        end
    endtask

    task automatic script(input int f, input int h);
        case (f)
            0: begin // R8 random scroll, R6 inversion on
                if (h == 0) do_read(1'b1, {8'hE2, 8'(rnd_scroll)});
                if (h == 1) do_read(1'b1, 16'hE015);
            end
            1: begin // R8 wrap case, R7 clear, R9 ignored accesses
                if (h == 0) do_read(1'b1, 16'hE2FF);
                if (h == 1) do_read(1'b1, 16'hE014);
                if (h == 2) do_read(1'b1, 16'hE300);
                if (h == 3) do_read(1'b1, 16'hE016);
                if (h == 4) do_read(1'b0, 16'hE240);
                if (h == 5) do_read(1'b1, 16'hE1FF);
                if (h == 6) do_read(1'b0, 16'hE015);
            end
            2: begin // R5 gate low together with R6 inversion
                if (h == 0) begin gate = 1'b0; m_gate = 1'b0; end
                if (h == 1) do_read(1'b1, 16'hE015);
                if (h == 2) do_read(1'b0, 16'hE014);
            end
            default: ;
        endcase
    endtask

    initial begin
        void'($urandom(32'd7717));
        for (int i = 0; i < 2048; i++) begin
            vram_mem[i] = 8'($urandom);
            pat_mem[i]  = 8'($urandom);
        end
        rnd_scroll = int'($urandom_range(1, 254));
        repeat (3) @(negedge clk);
        // R12: outputs while reset is held
        chk(pix == 1'b0, "R12 pix", pix, 0);
        chk(line_start == 1'b1, "R12 line_start", line_start, 1);
        chk(frame_start == 1'b1, "R12 frame_start", frame_start, 1);
        chk(vdisp == 1'b1, "R12 vdisp", vdisp, 1);
        chk(hblank == 1'b1, "R12 hblank", hblank, 1);
        rst_n = 1'b1;
        for (int f = 0; f < 4; f++) begin
            case (f)
                0: tag = "R12 default scroll and reverse";
                1: tag = "R6 R8";
                2: tag = "R7 R9";
                default: tag = "R5 R6";
            endcase
            for (int v = 0; v < V_TOTAL; v++) begin
                for (int h = 0; h < H_TOTAL; h++) begin
                    check_cycle(h, v);
                    cpu_rd = 1'b0;
                    if (v == VIS + 1) script(f, h);
                    @(negedge clk);
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule